// File: doc/BRIEF.md
# Buck Converter Mode Sequencer

This block is the digital state controller for an on-chip step-down converter. It selects how the converter's power stage is driven: a pass-through mode in which the output follows the input supply, a switching mode in which the converter regulates, and an open mode in which the output is disconnected so that the bulk capacitor keeps its charge. The analog loop, the trimming and the comparators are outside the block. They appear here as a brown-out-high input, a minimum-voltage-good input and a target-voltage-good input.

Software writes a small register file over a simple synchronous interface. Through it, software sets the enable bit, chooses the brown-out policy (force pass-through or request a system reset), enables the interrupt, and sets the output-voltage and current-limit codes. Low-power entry and exit requests move a regulating converter into open mode and back. After a wakeup the CPU stays held until the output is above the minimum voltage. A brown-out under the pass-through policy clears the enable bit and sets a sticky flag, so that returning to regulation is always a deliberate software action.

Top module: `buck_mode_seq`

## Requirements
- R1: After `rst`, the drive mode is pass-through, `bypass`=1, `ready`=0, `cpu_release`=1, `fb_flag`=0, `irq`=0, `rst_req`=0, `ilim`=7, `vcode` equals `trim_code`, and the control register (address 0) reads 0x70.
- R2: When `bor_high`=1 while the enable bit and the brown-out policy bit are both 1, the next edge puts the block in pass-through (`drv_mode`=0, `bypass`=1) and clears the enable bit (bit 0 of address 0).
- R3: When `bor_high`=1 with the policy bit at 0, `rst_req` is 1 after the next edge, and neither the mode nor the flag changes.
- R4: A forced pass-through sets `fb_flag`, which stays set until a write to address 3 with bit 0 = 1. `irq` equals `fb_flag` AND the interrupt-enable bit. Address 3 always reads 0. If a set and a clear arrive in the same cycle, the set wins.
- R5: After a forced pass-through, the block stays in pass-through until software writes the enable bit back to 1.
- R6: Once enabled, the block leaves pass-through into a ramp state (`drv_mode`=1, `ready`=0, `bypass`=0). It moves to regulation (`ready`=1) only when `vtgt_ok` is 1. `vmin_ok` alone does not complete the ramp.
- R7: `lp_enter` during regulation selects open mode (`drv_mode`=2, `cpu_release`=0). `lp_exit` then restarts switching with the CPU still held. The CPU is released, back in regulation, only once `vmin_ok`=1. `vtgt_ok` alone does not release it.
- R8: A brown-out that forces pass-through takes priority over `lp_exit` in open mode and over `vmin_ok` during wakeup.
- R9: Clearing the enable bit returns the block to pass-through on the edge after the write takes effect.
- R10: `stby_wake` returns the block to pass-through and reloads `vcode` from `trim_code`. The enable bit, policy bit, interrupt enable, current limit and `fb_flag` keep their values.
- R11: The control register at address 0 holds the enable bit in bit 0, the policy bit in bit 1, the interrupt enable in bit 2 and the current limit in bits 6:4. The voltage code is at address 1. The status register at address 2 holds `ready` in bit 0, `bypass` in bit 1, the flag in bit 2 and the state code in bits 6:4: 0 pass-through, 1 ramp, 2 regulating, 3 open, 4 wakeup. `state_chg` is high for exactly the first cycle in which a new state is visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| stby_wake | input | 1 | Standby-exit reset pulse (partial reset) |
| bor_high | input | 1 | Brown-out-high comparator |
| lp_enter | input | 1 | Request to enter a stop mode |
| lp_exit | input | 1 | Wakeup request from a stop mode |
| vmin_ok | input | 1 | Output above the minimum operating voltage |
| vtgt_ok | input | 1 | Output at the programmed target voltage |
| trim_code | input | VCODE_W | Factory voltage code loaded at reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| drv_mode | output | 2 | Power-stage mode: 0 pass-through, 1 switching, 2 open |
| ready | output | 1 | Regulating at the target voltage |
| bypass | output | 1 | In pass-through |
| fb_flag | output | 1 | Sticky forced-pass-through flag |
| irq | output | 1 | Interrupt request |
| rst_req | output | 1 | System reset request on brown-out |
| cpu_release | output | 1 | CPU may run |
| state_chg | output | 1 | One-cycle pulse on a state change |
| vcode | output | VCODE_W | Output-voltage code |
| ilim | output | ILIM_W | Current-limit code |

## Verification
A table of input patterns takes the block through power-up, ramp, regulation, stop entry, wakeup and disable. The ramp is tried with only the minimum-voltage input, and the wakeup with only the target-voltage input. These cases show that each state waits for its own comparator and not the other one. The brown-out is applied under both policies and in both the regulating and the open state, so the bench can tell a forced pass-through from a reset request and confirm its priority over a wakeup. Directed cases check that the flag survives a standby exit while the voltage code is reloaded, and that a flag set wins over a flag clear in the same cycle.

// File: rtl/buck_seq_pkg.sv
package buck_seq_pkg;

    localparam int ILIM_W_P = 3;

    typedef enum logic [2:0] {
        ST_BYPASS = 3'd0,
        ST_RAMP   = 3'd1,
        ST_RUN    = 3'd2,
        ST_OPEN   = 3'd3,
        ST_WAKE   = 3'd4
    } seq_state_t;

    typedef enum logic [1:0] {
        DRV_BYPASS = 2'd0,
        DRV_SWITCH = 2'd1,
        DRV_OPEN   = 2'd2
    } drv_mode_t;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_VOLT = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;
    localparam logic [1:0] ADDR_CLR  = 2'd3;

    function automatic drv_mode_t mode_of(seq_state_t s);
        case (s)
            ST_RAMP, ST_RUN, ST_WAKE: mode_of = DRV_SWITCH;
            ST_OPEN:                  mode_of = DRV_OPEN;
            default:                  mode_of = DRV_BYPASS;
        endcase
    endfunction

endpackage

// File: rtl/buck_seq_regs.sv
module buck_seq_regs
    import buck_seq_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 2,
    parameter int VCODE_W  = 4,
    parameter int ILIM_W   = ILIM_W_P,
    parameter int ILIM_RST = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               stby_wake,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    input  logic [VCODE_W-1:0] trim_code,
    input  logic               force_byp,
    input  logic               st_ready,
    input  logic               st_bypass,
    input  logic               st_flag,
    input  seq_state_t         st_state,
    output logic               ctrl_en,
    output logic               ctrl_bor_cfg,
    output logic               ctrl_irq_en,
    output logic [ILIM_W-1:0]  ctrl_ilim,
    output logic [VCODE_W-1:0] vcode,
    output logic               clr_hit,
    output logic [DATA_W-1:0]  reg_rdata
);
    localparam int ILIM_LSB = 4;

    logic wr_ctrl, wr_volt;

    assign wr_ctrl = reg_wr && (reg_addr == ADDR_W'(ADDR_CTRL));
    assign wr_volt = reg_wr && (reg_addr == ADDR_W'(ADDR_VOLT));
    assign clr_hit = reg_wr && (reg_addr == ADDR_W'(ADDR_CLR)) && reg_wdata[0];

    // Control fields: only a power-on reset touches them
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_en      <= 1'b0;
            ctrl_bor_cfg <= 1'b0;
            ctrl_irq_en  <= 1'b0;
            ctrl_ilim    <= ILIM_W'(ILIM_RST);
        end else begin
            if (wr_ctrl) begin
                ctrl_bor_cfg <= reg_wdata[1];
                ctrl_irq_en  <= reg_wdata[2];
                ctrl_ilim    <= reg_wdata[ILIM_LSB +: ILIM_W];
            end
            if (force_byp)
                ctrl_en <= 1'b0;
            else if (wr_ctrl)
                ctrl_en <= reg_wdata[0];
        end
    end

    // Voltage code: reloaded from trim on both kinds of reset
    always_ff @(posedge clk) begin
        if (rst || stby_wake)
            vcode <= trim_code;
        else if (wr_volt)
            vcode <= reg_wdata[VCODE_W-1:0];
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_W'(ADDR_CTRL): begin
                reg_rdata[0] = ctrl_en;
                reg_rdata[1] = ctrl_bor_cfg;
                reg_rdata[2] = ctrl_irq_en;
                reg_rdata[ILIM_LSB +: ILIM_W] = ctrl_ilim;
            end
            ADDR_W'(ADDR_VOLT): reg_rdata[VCODE_W-1:0] = vcode;
            ADDR_W'(ADDR_STAT): begin
                reg_rdata[0]     = st_ready;
                reg_rdata[1]     = st_bypass;
                reg_rdata[2]     = st_flag;
                reg_rdata[6:4]   = st_state;
            end
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/buck_seq_fsm.sv
module buck_seq_fsm
    import buck_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       stby_wake,
    input  logic       en,
    input  logic       bor_high,
    input  logic       bor_cfg,
    input  logic       lp_enter,
    input  logic       lp_exit,
    input  logic       vmin_ok,
    input  logic       vtgt_ok,
    output seq_state_t state,
    output logic       force_byp,
    output logic       state_chg
);
    seq_state_t nxt;

    assign force_byp = bor_high && bor_cfg && en;

    always_comb begin
        nxt = state;
        if (force_byp || !en) begin
            nxt = ST_BYPASS;
        end else begin
            case (state)
                ST_BYPASS: nxt = ST_RAMP;
                ST_RAMP:   if (vtgt_ok)  nxt = ST_RUN;
                ST_RUN:    if (lp_enter) nxt = ST_OPEN;
                ST_OPEN:   if (lp_exit)  nxt = ST_WAKE;
                ST_WAKE:   if (vmin_ok)  nxt = ST_RUN;
                default:   nxt = ST_BYPASS;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_BYPASS;
            state_chg <= 1'b0;
        end else if (stby_wake) begin
            state     <= ST_BYPASS;
            state_chg <= (state != ST_BYPASS);
        end else begin
            state     <= nxt;
            state_chg <= (nxt != state);
        end
    end
endmodule

// File: rtl/buck_seq_flag.sv
module buck_seq_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_evt,
    input  logic clr_evt,
    input  logic bor_high,
    input  logic bor_cfg,
    input  logic irq_en,
    output logic flag,
    output logic irq,
    output logic rst_req
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag    <= 1'b0;
            rst_req <= 1'b0;
        end else begin
            if (set_evt)
                flag <= 1'b1;
            else if (clr_evt)
                flag <= 1'b0;
            rst_req <= bor_high && !bor_cfg;
        end
    end

    assign irq = flag && irq_en;
endmodule

// File: rtl/buck_mode_seq.sv
module buck_mode_seq
    import buck_seq_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 2,
    parameter int VCODE_W  = 4,
    parameter int ILIM_W   = ILIM_W_P,
    parameter int ILIM_RST = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               stby_wake,
    input  logic               bor_high,
    input  logic               lp_enter,
    input  logic               lp_exit,
    input  logic               vmin_ok,
    input  logic               vtgt_ok,
    input  logic [VCODE_W-1:0] trim_code,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic [1:0]         drv_mode,
    output logic               ready,
    output logic               bypass,
    output logic               fb_flag,
    output logic               irq,
    output logic               rst_req,
    output logic               cpu_release,
    output logic               state_chg,
    output logic [VCODE_W-1:0] vcode,
    output logic [ILIM_W-1:0]  ilim
);
    seq_state_t state;
    logic ctrl_en, ctrl_bor_cfg, ctrl_irq_en;
    logic force_byp, clr_hit;

    buck_seq_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .stby_wake (stby_wake),
        .en        (ctrl_en),
        .bor_high  (bor_high),
        .bor_cfg   (ctrl_bor_cfg),
        .lp_enter  (lp_enter),
        .lp_exit   (lp_exit),
        .vmin_ok   (vmin_ok),
        .vtgt_ok   (vtgt_ok),
        .state     (state),
        .force_byp (force_byp),
        .state_chg (state_chg)
    );

    buck_seq_flag u_flag (
        .clk      (clk),
        .rst      (rst),
        .set_evt  (force_byp),
        .clr_evt  (clr_hit),
        .bor_high (bor_high),
        .bor_cfg  (ctrl_bor_cfg),
        .irq_en   (ctrl_irq_en),
        .flag     (fb_flag),
        .irq      (irq),
        .rst_req  (rst_req)
    );

    buck_seq_regs #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .VCODE_W  (VCODE_W),
        .ILIM_W   (ILIM_W),
        .ILIM_RST (ILIM_RST)
    ) u_regs (
        .clk          (clk),
        .rst          (rst),
        .stby_wake    (stby_wake),
        .reg_wr       (reg_wr),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .trim_code    (trim_code),
        .force_byp    (force_byp),
        .st_ready     (ready),
        .st_bypass    (bypass),
        .st_flag      (fb_flag),
        .st_state     (state),
        .ctrl_en      (ctrl_en),
        .ctrl_bor_cfg (ctrl_bor_cfg),
        .ctrl_irq_en  (ctrl_irq_en),
        .ctrl_ilim    (ilim),
        .vcode        (vcode),
        .clr_hit      (clr_hit),
        .reg_rdata    (reg_rdata)
    );

    assign drv_mode    = mode_of(state);
    assign ready       = (state == ST_RUN);
    assign bypass      = (state == ST_BYPASS);
    assign cpu_release = !((state == ST_OPEN) || (state == ST_WAKE));
endmodule

// File: rtl/buck_seq_chk.sv
module buck_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       bor_high,
    input logic       bor_cfg,
    input logic       en,
    input logic [1:0] drv_mode,
    input logic       ready,
    input logic       bypass,
    input logic       fb_flag,
    input logic       clr_hit,
    input logic       cpu_release
);
    a_r2_forced_bypass: assert property (@(posedge clk) disable iff (rst)
        (bor_high && bor_cfg && en) |=> (drv_mode == 2'd0 && bypass && !en));

    a_r4_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (fb_flag && !clr_hit) |=> fb_flag);

    a_r5_stay_bypass: assert property (@(posedge clk) disable iff (rst)
        (bypass && !en) |=> bypass);

    a_r6_ready_switching: assert property (@(posedge clk) disable iff (rst)
        ready |-> (drv_mode == 2'd1 && !bypass && cpu_release));

    a_r7_open_holds_cpu: assert property (@(posedge clk) disable iff (rst)
        (drv_mode == 2'd2) |-> !cpu_release);

    a_r9_disable_returns: assert property (@(posedge clk) disable iff (rst)
        (!en && !bypass) |=> bypass);
endmodule

bind buck_mode_seq buck_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .bor_high    (bor_high),
    .bor_cfg     (ctrl_bor_cfg),
    .en          (ctrl_en),
    .drv_mode    (drv_mode),
    .ready       (ready),
    .bypass      (bypass),
    .fb_flag     (fb_flag),
    .clr_hit     (clr_hit),
    .cpu_release (cpu_release)
);

// File: tb/buck_mode_seq_test.sv
`timescale 1ns/1ps
module buck_mode_seq_test;
    logic       clk = 1'b0;
    logic       rst, stby_wake, bor_high, lp_enter, lp_exit, vmin_ok, vtgt_ok;
    logic [3:0] trim_code;
    logic       reg_wr;
    logic [1:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic [1:0] drv_mode;
    logic       ready, bypass, fb_flag, irq, rst_req, cpu_release, state_chg;
    logic [3:0] vcode;
    logic [2:0] ilim;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    buck_mode_seq uut (
        .clk(clk), .rst(rst), .stby_wake(stby_wake), .bor_high(bor_high),
        .lp_enter(lp_enter), .lp_exit(lp_exit), .vmin_ok(vmin_ok), .vtgt_ok(vtgt_ok),
        .trim_code(trim_code), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .drv_mode(drv_mode),
        .ready(ready), .bypass(bypass), .fb_flag(fb_flag), .irq(irq),
        .rst_req(rst_req), .cpu_release(cpu_release), .state_chg(state_chg),
        .vcode(vcode), .ilim(ilim)
    );

    // {wr_en1, wr_en0, lp_enter, lp_exit, vmin, vtgt, bor, exp_mode[1:0], exp_ready, exp_release, exp_bypass}
    localparam logic [11:0] VEC [15] = '{
        {7'b1000000, 2'd0, 3'b011},  // write enable: still pass-through
        {7'b0000000, 2'd1, 3'b010},  // ramp
        {7'b0000100, 2'd1, 3'b010},  // minimum only: ramp holds
        {7'b0000010, 2'd1, 3'b110},  // target reached: regulating
        {7'b0010000, 2'd2, 3'b000},  // stop entry: open
        {7'b0000100, 2'd2, 3'b000},  // no exit: open holds
        {7'b0001000, 2'd1, 3'b000},  // wakeup, CPU held
        {7'b0000010, 2'd1, 3'b000},  // target only: still held
        {7'b0000100, 2'd1, 3'b110},  // minimum good: released
        {7'b0100000, 2'd1, 3'b110},  // disable write takes effect
        {7'b0000000, 2'd0, 3'b011},  // back to pass-through
        {7'b1000000, 2'd0, 3'b011},  // re-enable
        {7'b0000000, 2'd1, 3'b010},  // ramp
        {7'b0000001, 2'd0, 3'b011},  // brown-out forces pass-through
        {7'b0000000, 2'd0, 3'b011}   // stays there
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        reg_addr = a;
        #0.5;
        v = int'(reg_rdata);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int v;
        rst = 1; stby_wake = 0; bor_high = 0; lp_enter = 0; lp_exit = 0;
        vmin_ok = 0; vtgt_ok = 0; trim_code = 4'd5;
        reg_wr = 0; reg_addr = 0; reg_wdata = 0;
        repeat (3) tick();
        rst = 0;
        tick();

        // R1 reset state
        chk("R1 mode", drv_mode, 0);
        chk("R1 bypass", bypass, 1);
        chk("R1 ready", ready, 0);
        chk("R1 release", cpu_release, 1);
        chk("R1 flag", fb_flag, 0);
        chk("R1 irq", irq, 0);
        chk("R1 rst_req", rst_req, 0);
        chk("R1 ilim", ilim, 7);
        chk("R1 vcode", vcode, 5);
        rd(2'd0, v); chk("R1 ctrl", v, 8'h70);

        // Table: R6 R7 R9 R2 R5
        for (int i = 0; i < 15; i++) begin
            logic [11:0] e;
            e = VEC[i];
            if (e[11] || e[10]) begin
                reg_wr = 1'b1; reg_addr = 2'd0;
                reg_wdata = e[11] ? 8'h77 : 8'h76;
            end
            lp_enter = e[9]; lp_exit = e[8]; vmin_ok = e[7]; vtgt_ok = e[6]; bor_high = e[5];
            tick();
            reg_wr = 0; lp_enter = 0; lp_exit = 0; vmin_ok = 0; vtgt_ok = 0; bor_high = 0;
            chk($sformatf("R6/R7/R9/R2/R5 step %0d mode", i), drv_mode, int'(e[4:3]));
            chk($sformatf("R6/R7 step %0d ready", i), ready, int'(e[2]));
            chk($sformatf("R7 step %0d release", i), cpu_release, int'(e[1]));
            chk($sformatf("R5 step %0d bypass", i), bypass, int'(e[0]));
        end

        // R4 flag and interrupt after forced pass-through; R2 enable cleared
        chk("R4 flag set", fb_flag, 1);
        chk("R4 irq", irq, 1);
        rd(2'd0, v); chk("R2 en cleared", v, 8'h76);
        wr(2'd0, 8'h72);
        chk("R4 irq masked", irq, 0);
        chk("R4 flag kept", fb_flag, 1);
        wr(2'd3, 8'h01);
        chk("R4 flag cleared", fb_flag, 0);
        rd(2'd3, v); chk("R4 clear reads 0", v, 0);
        rd(2'd2, v); chk("R11 status", v, 8'h02);

        // R3 reset-request policy
        wr(2'd0, 8'h70);
        bor_high = 1; tick(); bor_high = 0;
        chk("R3 rst_req", rst_req, 1);
        chk("R3 bypass", bypass, 1);
        chk("R3 no flag", fb_flag, 0);
        tick();
        chk("R3 rst_req drops", rst_req, 0);
        wr(2'd0, 8'h71);
        tick();
        vtgt_ok = 1; tick(); vtgt_ok = 0;
        chk("R3 running", ready, 1);
        bor_high = 1; tick(); bor_high = 0;
        chk("R3 mode kept", drv_mode, 1);
        chk("R3 ready kept", ready, 1);
        chk("R3 rst_req run", rst_req, 1);
        chk("R3 no flag run", fb_flag, 0);

        // R11 state change pulse and state readback; R8 priority
        wr(2'd0, 8'h73);
        lp_enter = 1; tick(); lp_enter = 0;
        chk("R11 chg pulse", state_chg, 1);
        rd(2'd2, v); chk("R11 open code", v, 8'h30);
        tick();
        chk("R11 chg single", state_chg, 0);
        lp_exit = 1; bor_high = 1; tick(); lp_exit = 0; bor_high = 0;
        chk("R8 bypass over exit", bypass, 1);
        chk("R8 mode", drv_mode, 0);
        chk("R8 flag", fb_flag, 1);
        chk("R8 release", cpu_release, 1);
        rd(2'd0, v); chk("R8 en cleared", v, 8'h72);

        // R10 standby exit
        wr(2'd1, 8'h09);
        rd(2'd1, v); chk("R11 vcode rb", v, 9);
        wr(2'd0, 8'h77);
        tick();
        chk("R10 ramp before", drv_mode, 1);
        stby_wake = 1; tick(); stby_wake = 0;
        chk("R10 bypass", bypass, 1);
        chk("R10 vcode reload", vcode, 5);
        chk("R10 flag kept", fb_flag, 1);
        rd(2'd0, v); chk("R10 ctrl kept", v, 8'h77);
        tick();
        chk("R10 en kept ramps", drv_mode, 1);

        // R4 set wins over clear
        wr(2'd3, 8'h01);
        chk("R4 cleared again", fb_flag, 0);
        reg_wr = 1; reg_addr = 2'd3; reg_wdata = 8'h01; bor_high = 1;
        tick();
        reg_wr = 0; reg_wdata = 0; bor_high = 0;
        chk("R4 set wins", fb_flag, 1);
        chk("R4 irq on", irq, 1);
        chk("R2 bypass", bypass, 1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule